// File: doc/BRIEF.md
# Dispatch Group Slot Accountant

This block keeps count of the dispatch slots that the instruction group being formed has already used. It is meant for an issue-ordering engine that offers instructions one at a time. Each offered instruction is described by several inputs: a slot-cost class, a record-form flag, a forced-lead flag, a branch flag, and a flag that marks a load that depends on a store already in the group. From these the block works out the slot count and the branch occupancy of the group. It also flags whether the instruction opened a fresh group, whether the scheduler should prefer a different candidate, and how many no-ops must be padded in front of a conflicting load. The engine can also insert an explicit no-op. A mode input selects whether a single group-terminating no-op is available.

Instructions come in on `issue_valid` and explicit no-ops on `noop_valid`. There is no back-pressure: one event is accepted in every clock cycle, so no ready signal exists. All outputs are registered. They describe the event accepted at the previous rising edge. `prefer_other` and `nops_needed` are evaluated against the group state as it was before that event. `slots_used`, `branch_in_group` and `opened_group` show the state after it.

Top module: `dgsa_slot_acct`

## Requirements
- R1: The cost class sets the slot cost: 2'd0 costs 1 slot, 2'd1 costs 2 slots, and 2'd2 and 2'd3 cost 4 slots. An accepted instruction adds its cost to `slots_used`.
- R2: A class-0 instruction that has `has_record_form` high costs 2 slots instead of 1.
- R3: An instruction must lead its group when its cost exceeds 1 or when `force_lead` is high. If such an instruction arrives while `slots_used` is nonzero, the group is cleared first. Afterwards `slots_used` equals its cost, and `branch_in_group` reflects only this instruction.
- R4: `opened_group` is 1 for one cycle after an instruction that was counted starting from an empty slot count. It is 0 after every other event.
- R5: An instruction that arrives while `slots_used` is 5 is not counted. The slot count becomes 0 and the branch flag becomes 0.
- R6: A branch that arrives while `branch_in_group` is 1 is not counted either. The slot count becomes 0 and the branch flag becomes 0.
- R7: `nops_needed` reports the padding for an instruction with `lds_hazard` high that arrives while `slots_used` is below 6. The value is 1 when `term_nop_mode` is high, and 5 minus `slots_used` otherwise. In all other cases it is 0.
- R8: `prefer_other` is 1 exactly when the accepted instruction must lead its group (per R3) and `slots_used` was nonzero.
- R9: An explicit no-op closes the group (slots and branch flag return to 0) when `term_nop_mode` is high or `slots_used` is 6. Otherwise it adds one slot.
- R10: When both valids are high, the instruction is accepted and the no-op is ignored. `slots_used` saturates at 15.
- R11: A synchronous active-low reset returns every output to 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_valid | input | 1 | An instruction is offered this cycle |
| cost_class | input | 2 | Slot-cost class of the instruction |
| has_record_form | input | 1 | Instruction also sets condition flags |
| force_lead | input | 1 | Instruction must lead its group whatever its cost |
| is_branch | input | 1 | Instruction is a branch |
| lds_hazard | input | 1 | Load depends on a store in the current group |
| noop_valid | input | 1 | An explicit no-op is inserted this cycle |
| term_nop_mode | input | 1 | A group-terminating no-op is available |
| slots_used | output | 4 | Slots used by the current group |
| branch_in_group | output | 1 | The group already holds a branch |
| opened_group | output | 1 | The last instruction started a fresh group |
| prefer_other | output | 1 | The last instruction should have been deferred |
| nops_needed | output | 3 | No-ops to pad ahead of the last load |

## Verification
The assertions assume that reset is held low through the first rising edge. They also assume that every input is driven to a known level in every cycle, and they allow both valids to be high together. The stimulus sets all inputs on the falling edge. It mixes directed sequences that drive the slot count into the states 5, 6 and 15 with a pseudo-random stretch over every class and flag combination. During that stretch `term_nop_mode` is occasionally flipped, and reset is applied once in the middle of the run.

// File: rtl/dgsa_pkg.sv
package dgsa_pkg;
  typedef enum logic [1:0] {
    CLS_SINGLE = 2'd0,
    CLS_DOUBLE = 2'd1,
    CLS_QUAD   = 2'd2,
    CLS_QUAD_B = 2'd3
  } cost_cls_e;

  function automatic logic [2:0] class_cost(cost_cls_e c, logic rec_form);
    logic [2:0] r;
    case (c)
      CLS_SINGLE: r = rec_form ? 3'd2 : 3'd1;
      CLS_DOUBLE: r = 3'd2;
      default:    r = 3'd4;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/dgsa_cost.sv
module dgsa_cost
  import dgsa_pkg::*;
(
  input  logic [1:0] cls,
  input  logic       rec_form,
  input  logic       force_lead,
  output logic [2:0] cost,
  output logic       lead
);
  always_comb begin
    cost = class_cost(cost_cls_e'(cls), rec_form);
    // multi-slot instructions always lead their group
    lead = (cost > 3'd1) || force_lead;
  end
endmodule

// File: rtl/dgsa_pad.sv
module dgsa_pad #(
  parameter int SLOT_W      = 4,
  parameter int GROUP_SLOTS = 5,
  parameter int PAD_W       = 3
) (
  input  logic              hazard,
  input  logic              term_mode,
  input  logic [SLOT_W-1:0] slots,
  output logic [PAD_W-1:0]  nops
);
  localparam logic [SLOT_W-1:0] PAD_LIMIT = SLOT_W'(GROUP_SLOTS + 1);
  localparam logic [SLOT_W-1:0] FILL_TO   = SLOT_W'(GROUP_SLOTS);

  logic [SLOT_W-1:0] gap;

  always_comb begin
    gap  = FILL_TO - slots;
    nops = '0;
    if (hazard && (slots < PAD_LIMIT)) begin
      if (term_mode) nops = PAD_W'(1);
      else           nops = gap[PAD_W-1:0];
    end
  end
endmodule

// File: rtl/dgsa_track.sv
module dgsa_track #(
  parameter int SLOT_W      = 4,
  parameter int GROUP_SLOTS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [2:0]        cost,
  input  logic              lead,
  input  logic              is_branch,
  input  logic              noop_valid,
  input  logic              term_mode,
  output logic [SLOT_W-1:0] slots_q,
  output logic              br_q,
  output logic              opened_q
);
  localparam int                SLOT_MAX  = (1 << SLOT_W) - 1;
  localparam logic [SLOT_W:0]   SUM_MAX   = (SLOT_W+1)'(SLOT_MAX);
  localparam logic [SLOT_W-1:0] SAT_VAL   = SLOT_W'(SLOT_MAX);
  localparam logic [SLOT_W-1:0] FULL      = SLOT_W'(GROUP_SLOTS);
  localparam logic [SLOT_W-1:0] NOP_CLOSE = SLOT_W'(GROUP_SLOTS + 1);

  logic              full_clr, lead_clr, base_br;
  logic [SLOT_W-1:0] base, added, slots_d, noop_inc;
  logic [SLOT_W:0]   sum;
  logic              br_d, opened_d;

  always_comb begin
    full_clr = (slots_q == FULL) || (is_branch && br_q);
    lead_clr = lead && (slots_q != '0);
    base     = lead_clr ? '0 : slots_q;
    base_br  = lead_clr ? 1'b0 : br_q;
    sum      = {1'b0, base} + (SLOT_W+1)'(cost);
    added    = (sum > SUM_MAX) ? SAT_VAL : sum[SLOT_W-1:0];
    noop_inc = (slots_q == SAT_VAL) ? slots_q : slots_q + 1'b1;

    slots_d  = slots_q;
    br_d     = br_q;
    opened_d = 1'b0;
    if (issue_valid) begin
      if (full_clr) begin
        slots_d = '0;
        br_d    = 1'b0;
      end else begin
        slots_d  = added;
        br_d     = base_br | is_branch;
        opened_d = (base == '0);
      end
    end else if (noop_valid) begin
      if (term_mode || (slots_q == NOP_CLOSE)) begin
        slots_d = '0;
        br_d    = 1'b0;
      end else begin
        slots_d = noop_inc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slots_q  <= '0;
      br_q     <= 1'b0;
      opened_q <= 1'b0;
    end else begin
      slots_q  <= slots_d;
      br_q     <= br_d;
      opened_q <= opened_d;
    end
  end
endmodule

// File: rtl/dgsa_slot_acct.sv
module dgsa_slot_acct #(
  parameter int SLOT_W      = 4,
  parameter int GROUP_SLOTS = 5,
  parameter int PAD_W       = $clog2(GROUP_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [1:0]        cost_class,
  input  logic              has_record_form,
  input  logic              force_lead,
  input  logic              is_branch,
  input  logic              lds_hazard,
  input  logic              noop_valid,
  input  logic              term_nop_mode,
  output logic [SLOT_W-1:0] slots_used,
  output logic              branch_in_group,
  output logic              opened_group,
  output logic              prefer_other,
  output logic [PAD_W-1:0]  nops_needed
);
  logic [2:0]       cost;
  logic             lead;
  logic [PAD_W-1:0] nops_d;

  dgsa_cost u_cost (
    .cls        (cost_class),
    .rec_form   (has_record_form),
    .force_lead (force_lead),
    .cost       (cost),
    .lead       (lead)
  );

  dgsa_pad #(.SLOT_W(SLOT_W), .GROUP_SLOTS(GROUP_SLOTS), .PAD_W(PAD_W)) u_pad (
    .hazard    (issue_valid && lds_hazard),
    .term_mode (term_nop_mode),
    .slots     (slots_used),
    .nops      (nops_d)
  );

  dgsa_track #(.SLOT_W(SLOT_W), .GROUP_SLOTS(GROUP_SLOTS)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .cost        (cost),
    .lead        (lead),
    .is_branch   (is_branch),
    .noop_valid  (noop_valid),
    .term_mode   (term_nop_mode),
    .slots_q     (slots_used),
    .br_q        (branch_in_group),
    .opened_q    (opened_group)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prefer_other <= 1'b0;
      nops_needed  <= '0;
    end else begin
      prefer_other <= issue_valid && lead && (slots_used != '0);
      nops_needed  <= nops_d;
    end
  end
endmodule

// File: rtl/dgsa_chk.sv
module dgsa_chk #(
  parameter int SLOT_W = 4,
  parameter int PAD_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue_valid,
  input logic [1:0]        cost_class,
  input logic              has_record_form,
  input logic              force_lead,
  input logic              is_branch,
  input logic              noop_valid,
  input logic              term_nop_mode,
  input logic [SLOT_W-1:0] slots_used,
  input logic              branch_in_group,
  input logic              prefer_other,
  input logic [PAD_W-1:0]  nops_needed
);
  a_r5_full_clears: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && slots_used == SLOT_W'(5) |=> slots_used == '0 && !branch_in_group);

  a_r6_second_branch: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && is_branch && branch_in_group |=> slots_used == '0);

  a_r8_prefer_lead: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && force_lead && slots_used != '0 |=> prefer_other);

  a_r9_term_noop: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid && noop_valid && term_nop_mode |=> slots_used == '0);

  a_r1_single_add: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && cost_class == 2'd0 && !has_record_form && !force_lead && !is_branch
    && slots_used < SLOT_W'(5) |=> slots_used == $past(slots_used) + 1'b1);

  a_r7_pad_bound: assert property (@(posedge clk) disable iff (!rst_n)
    nops_needed <= PAD_W'(5));

  a_r11_reset: assert property (@(posedge clk)
    !rst_n |=> slots_used == '0 && !branch_in_group && !prefer_other);
endmodule

bind dgsa_slot_acct dgsa_chk #(.SLOT_W(SLOT_W), .PAD_W(PAD_W)) u_chk (.*);

// File: tb/dgsa_slot_acct_tb.sv
`timescale 1ns/100ps
module dgsa_slot_acct_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       issue_valid = 0, has_record_form = 0, force_lead = 0, is_branch = 0;
  logic       lds_hazard = 0, noop_valid = 0, term_nop_mode = 0;
  logic [1:0] cost_class = 0;
  logic [3:0] slots_used;
  logic       branch_in_group, opened_group, prefer_other;
  logic [2:0] nops_needed;

  int errors = 0, checks = 0;
  int m_slots = 0, m_br = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dgsa_slot_acct u_dut (.*);

  task automatic compare(int es, int eb, int eo, int ep, int en, string tag);
    checks++;
    if (slots_used !== 4'(es) || branch_in_group !== 1'(eb) || opened_group !== 1'(eo)
        || prefer_other !== 1'(ep) || nops_needed !== 3'(en)) begin
      errors++;
      $display("FAIL %s: got slots=%0d br=%0d open=%0d pref=%0d nops=%0d exp %0d %0d %0d %0d %0d",
               tag, slots_used, branch_in_group, opened_group, prefer_other, nops_needed,
               es, eb, eo, ep, en);
    end
  endtask

  task automatic step(bit iv, bit [1:0] cls, bit rec, bit fl, bit br, bit lh,
                      bit nv, bit tm, string tag);
    int cost, lead, eo, ep, en, base, bbr;
    @(negedge clk);
    issue_valid = iv; cost_class = cls; has_record_form = rec; force_lead = fl;
    is_branch = br; lds_hazard = lh; noop_valid = nv; term_nop_mode = tm;
    cost = (cls == 0) ? (rec ? 2 : 1) : (cls == 1 ? 2 : 4);
    lead = (cost > 1 || fl) ? 1 : 0;
    eo = 0;
    ep = (iv && lead && m_slots != 0) ? 1 : 0;
    en = (iv && lh && m_slots < 6) ? (tm ? 1 : 5 - m_slots) : 0;
    if (iv) begin
      if (m_slots == 5 || (br && m_br == 1)) begin
        m_slots = 0; m_br = 0;
      end else begin
        base = (lead && m_slots != 0) ? 0 : m_slots;
        bbr  = (lead && m_slots != 0) ? 0 : m_br;
        eo = (base == 0) ? 1 : 0;
        m_slots = (base + cost > 15) ? 15 : base + cost;
        m_br = (bbr == 1 || br) ? 1 : 0;
      end
    end else if (nv) begin
      if (tm || m_slots == 6) begin m_slots = 0; m_br = 0; end
      else if (m_slots < 15) m_slots++;
    end
    @(posedge clk); #1;
    compare(m_slots, m_br, eo, ep, en, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; issue_valid = 0; noop_valid = 0;
    @(posedge clk); #1;
    m_slots = 0; m_br = 0;
    compare(0, 0, 0, 0, 0, "R11");
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got running exp finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 / R5: fill with single-slot instructions, the sixth is not counted
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, 0, 0, 0, "R1");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R5");
    step(1, 1, 0, 0, 0, 0, 0, 0, "R1");   // empty group: 2 slots, opens
    step(1, 0, 0, 0, 0, 0, 0, 0, "R4");   // 3, not opened
    step(1, 2, 0, 0, 0, 0, 0, 0, "R3");   // lead clears then 4
    step(1, 0, 1, 0, 0, 0, 0, 0, "R2");   // record form -> 2, leads
    step(1, 0, 0, 1, 1, 0, 0, 0, "R3");   // forced lead branch -> 1, br
    step(1, 0, 0, 0, 1, 0, 0, 0, "R6");   // second branch clears
    step(1, 0, 0, 0, 1, 0, 0, 0, "R6");   // branch into empty
    step(1, 1, 0, 0, 0, 0, 0, 0, "R8");   // prefer_other, br dropped
    step(1, 0, 0, 0, 0, 1, 0, 0, "R7");   // 2 used: pad 3
    step(1, 0, 0, 0, 0, 1, 0, 1, "R7");   // term mode: 1
    step(0, 0, 0, 0, 0, 0, 1, 0, "R9");   // 4->5
    step(0, 0, 0, 0, 0, 0, 1, 0, "R9");   // 5->6
    step(1, 0, 0, 0, 0, 1, 0, 0, "R7");   // 6 used: no pad, instr -> 7
    step(0, 0, 0, 0, 0, 0, 1, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 1, 1, "R9");   // term closes
    // R10: saturation via no-ops and singles above 6
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 0, 1, 0, "R9");
    for (int i = 0; i < 11; i++) step(1, 0, 0, 0, 0, 0, 0, 0, "R10");
    step(1, 0, 0, 0, 0, 0, 1, 1, "R10");  // both valid: no-op ignored
    do_reset();
    for (int i = 0; i < 400; i++) begin
      bit [3:0] r = 4'($urandom_range(0, 15));
      step(r[0] | r[1], 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 7) == 0), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), ~r[0], ($urandom_range(0, 5) == 0), "R1");
      if (i == 200) do_reset();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule